// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a bank of hardware queues behind a plain 32-bit register bus. Each queue has a read pointer, a write pointer, an occupancy count derived from the adds it has accepted, a configured power-of-two size and four sticky status flags. Software never loads a pointer directly. It writes a small increment to one of two add registers, and the controller advances the pointer modulo the queue size. Software reads both pointers back, together with their flags, through two status registers.

Producers and consumers that share a ring in host memory use the block to exchange positions. The producer advances the write pointer after filling entries. The consumer advances the read pointer after draining them. Status reads report where each side stands and whether an add was rejected, overran the queue or ran past the producer. Each queue's size comes from a live configuration input as a base-2 logarithm. Values above the pointer width are clamped to it.

Top module: `qptr_ctrl`

## Requirements
- R1: Queue q owns the byte window starting at 0x80000 + q*0x800. The queue number is address bits 18:11, address bit 19 must be 1, and only q < NUM_Q is mapped. An access to one queue never changes another queue.
- R2: A write of v (0..63) to window offset 0x000 advances the read pointer by v modulo the queue size. The occupancy falls by v when v does not exceed it.
- R3: A write of v (0..63) to window offset 0x004 advances the write pointer by v modulo the queue size, wrapping to the low end. The occupancy rises by v.
- R4: A read of offset 0x008 returns the read pointer in bits 17:0. A read of offset 0x00C returns the write pointer in bits 17:0. Bits 29:18 of both reads are zero.
- R5: An add value above 63 leaves the pointers unchanged. It sets a sticky error flag in the 0x008 register: bit 31 for a write-pointer add, bit 30 for a read-pointer add.
- R6: A write-pointer add that takes the occupancy above the queue size sets sticky bit 31 of the 0x00C register. The pointer still advances, and the occupancy saturates at the size.
- R7: A read-pointer add larger than the occupancy sets sticky bit 30 of the 0x00C register and leaves the read pointer unchanged.
- R8: A read of 0x008 or 0x00C returns the flags as they stood and then clears the flags of that register, for that queue only.
- R9: Reads of unmapped addresses return zero. Writes to unmapped addresses, and writes to the two status offsets, change no state.
- R10: Every access is completed by bus_ready high for exactly the next cycle. bus_rdata is zero whenever no read is completing. A write asserted together with a read takes precedence, and the read is dropped.
- R11: After reset all pointers, occupancies and flags are zero, and bus_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 20 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data (add value) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Completion, one cycle after the strobe |
| q_size_log2 | input | NUM_Q*5 | Per-queue base-2 logarithm of the size, queue 0 in the low field |

## Verification
The embedded properties check the cycle-level rules on every cycle:
- the one-cycle completion pulse and quiet idle data;
- rejection of oversized adds with an unchanged pointer;
- a rejected underflow holding the read pointer;
- sticky flags surviving until their clearing read;
- zero data on unmapped reads.

Pointer arithmetic is checked only by the bench's scenarios, against a reference model built from the requirements. These scenarios cover:
- wrap at several sizes;
- a walk of the 18-bit pointer to its all-ones value;
- saturation of the occupancy;
- isolation between queues;
- flags being cleared by reads.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    localparam int unsigned BUS_AW   = 20;
    localparam int unsigned BUS_DW   = 32;
    localparam int unsigned WIN_LOG2 = 11;
    localparam int unsigned QNUM_W   = 8;
    localparam int unsigned LOG_W    = 5;

    localparam logic [WIN_LOG2-1:0] OFF_ADD_RD = 11'h000;
    localparam logic [WIN_LOG2-1:0] OFF_ADD_WR = 11'h004;
    localparam logic [WIN_LOG2-1:0] OFF_STS_RD = 11'h008;
    localparam logic [WIN_LOG2-1:0] OFF_STS_WR = 11'h00C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADD_RD,
        SEL_ADD_WR,
        SEL_STS_RD,
        SEL_STS_WR
    } qpc_sel_e;

endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
#(
    parameter int unsigned NUM_Q = 4,
    localparam int unsigned QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic [BUS_AW-1:0] addr,
    output qpc_sel_e          sel,
    output logic [QSEL_W-1:0] qidx
);

    localparam logic [QNUM_W:0] NQ_LIM = (QNUM_W+1)'(NUM_Q);

    logic [QNUM_W-1:0]   win_idx;
    logic [WIN_LOG2-1:0] win_off;
    logic                region_hit;
    logic                queue_hit;

    always_comb begin
        win_idx    = addr[WIN_LOG2 +: QNUM_W];
        win_off    = addr[WIN_LOG2-1:0];
        region_hit = addr[BUS_AW-1];
        queue_hit  = region_hit && ({1'b0, win_idx} < NQ_LIM);
        qidx       = win_idx[QSEL_W-1:0];
        sel        = SEL_NONE;
        if (queue_hit) begin
            unique case (win_off)
                OFF_ADD_RD: sel = SEL_ADD_RD;
                OFF_ADD_WR: sel = SEL_ADD_WR;
                OFF_STS_RD: sel = SEL_STS_RD;
                OFF_STS_WR: sel = SEL_STS_WR;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/qpc_queue.sv
module qpc_queue
    import qpc_pkg::*;
#(
    parameter int unsigned PTR_W    = 18,
    parameter int unsigned STEP_MAX = 63,
    localparam int unsigned SZ_W    = PTR_W + 1,
    localparam int unsigned STEP_W  = $clog2(STEP_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LOG_W-1:0]   size_log2,
    input  logic               add_rd,
    input  logic               add_wr,
    input  logic [BUS_DW-1:0]  add_val,
    input  logic               clr_err,
    input  logic               clr_flow,
    output logic [PTR_W-1:0]   rptr,
    output logic [PTR_W-1:0]   wptr,
    output logic               err_rd,
    output logic               err_wr,
    output logic               ovf,
    output logic               udf
);

    localparam logic [LOG_W-1:0] MAX_LOG = LOG_W'(PTR_W);

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
        logic [SZ_W-1:0]  occ;
        logic             err_rd;
        logic             err_wr;
        logic             ovf;
        logic             udf;
    } qst_t;

    qst_t st_d, st_q;

    logic [LOG_W-1:0] eff_log;
    logic [SZ_W-1:0]  size_v;
    logic [SZ_W-1:0]  mask_v;
    logic             step_ok;
    logic [SZ_W-1:0]  step;
    logic [SZ_W-1:0]  occ_sum;

    always_comb begin
        eff_log = (size_log2 > MAX_LOG) ? MAX_LOG : size_log2;
        size_v  = SZ_W'(1) << eff_log;
        mask_v  = size_v - SZ_W'(1);
        step_ok = (add_val <= BUS_DW'(STEP_MAX));
        step    = SZ_W'(add_val[STEP_W-1:0]);
        occ_sum = st_q.occ + step;

        st_d = st_q;
        if (clr_err) begin
            st_d.err_rd = 1'b0;
            st_d.err_wr = 1'b0;
        end
        if (clr_flow) begin
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end
        if (add_wr) begin
            if (!step_ok) begin
                st_d.err_wr = 1'b1;
            end else begin
                st_d.wptr = (st_q.wptr + step[PTR_W-1:0]) & mask_v[PTR_W-1:0];
                if (occ_sum > size_v) begin
                    st_d.ovf = 1'b1;
                    st_d.occ = size_v;
                end else begin
                    st_d.occ = occ_sum;
                end
            end
        end
        if (add_rd) begin
            if (!step_ok) begin
                st_d.err_rd = 1'b1;
            end else if (step > st_q.occ) begin
                st_d.udf = 1'b1;
            end else begin
                st_d.rptr = (st_q.rptr + step[PTR_W-1:0]) & mask_v[PTR_W-1:0];
                st_d.occ  = st_q.occ - step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rptr   = st_q.rptr;
    assign wptr   = st_q.wptr;
    assign err_rd = st_q.err_rd;
    assign err_wr = st_q.err_wr;
    assign ovf    = st_q.ovf;
    assign udf    = st_q.udf;

    // R5
    oversize_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_wr && !step_ok) |=> (err_wr && $stable(wptr)));

    // R5
    oversize_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_rd && !add_wr && !step_ok) |=> (err_rd && $stable(rptr)));

    // R7
    underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_rd && !add_wr && step_ok && (step > st_q.occ)) |=> (udf && $stable(rptr)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_flow) |=> ovf);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_rd || err_wr) && !clr_err) |=> (err_rd || err_wr));

endmodule

// File: rtl/qpc_rdmux.sv
module qpc_rdmux
    import qpc_pkg::*;
#(
    parameter int unsigned NUM_Q = 4,
    parameter int unsigned PTR_W = 18,
    localparam int unsigned QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  qpc_sel_e                     sel,
    input  logic [QSEL_W-1:0]            qidx,
    input  logic [NUM_Q-1:0][PTR_W-1:0]  rptr_all,
    input  logic [NUM_Q-1:0][PTR_W-1:0]  wptr_all,
    input  logic [NUM_Q-1:0]             err_rd_all,
    input  logic [NUM_Q-1:0]             err_wr_all,
    input  logic [NUM_Q-1:0]             ovf_all,
    input  logic [NUM_Q-1:0]             udf_all,
    output logic [BUS_DW-1:0]            rdata
);

    localparam int unsigned PAD_W = BUS_DW - 2 - PTR_W;

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_STS_RD: rdata = {err_wr_all[qidx], err_rd_all[qidx],
                                 {PAD_W{1'b0}}, rptr_all[qidx]};
            SEL_STS_WR: rdata = {ovf_all[qidx], udf_all[qidx],
                                 {PAD_W{1'b0}}, wptr_all[qidx]};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/qptr_ctrl.sv
module qptr_ctrl
    import qpc_pkg::*;
#(
    parameter int unsigned NUM_Q    = 4,
    parameter int unsigned PTR_W    = 18,
    parameter int unsigned STEP_MAX = 63
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [19:0]             bus_addr,
    input  logic                    bus_wr,
    input  logic [31:0]             bus_wdata,
    input  logic                    bus_rd,
    output logic [31:0]             bus_rdata,
    output logic                    bus_ready,
    input  logic [NUM_Q*LOG_W-1:0]  q_size_log2
);

    localparam int unsigned QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    typedef struct packed {
        logic              ready;
        logic [BUS_DW-1:0] rdata;
    } bus_st_t;

    bus_st_t bus_d, bus_q;

    qpc_sel_e          sel;
    logic [QSEL_W-1:0] qidx;
    logic              do_wr;
    logic              do_rd;
    logic [BUS_DW-1:0] mux_data;

    logic [NUM_Q-1:0][PTR_W-1:0] rptr_all;
    logic [NUM_Q-1:0][PTR_W-1:0] wptr_all;
    logic [NUM_Q-1:0]            err_rd_all;
    logic [NUM_Q-1:0]            err_wr_all;
    logic [NUM_Q-1:0]            ovf_all;
    logic [NUM_Q-1:0]            udf_all;

    assign do_wr = bus_wr;
    assign do_rd = bus_rd && !bus_wr;

    qpc_decode #(
        .NUM_Q (NUM_Q)
    ) decode_i (
        .addr (bus_addr),
        .sel  (sel),
        .qidx (qidx)
    );

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_queue
        logic hit_q;
        assign hit_q = (qidx == QSEL_W'(gi));

        qpc_queue #(
            .PTR_W    (PTR_W),
            .STEP_MAX (STEP_MAX)
        ) queue_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .size_log2 (q_size_log2[gi*LOG_W +: LOG_W]),
            .add_rd    (do_wr && hit_q && (sel == SEL_ADD_RD)),
            .add_wr    (do_wr && hit_q && (sel == SEL_ADD_WR)),
            .add_val   (bus_wdata),
            .clr_err   (do_rd && hit_q && (sel == SEL_STS_RD)),
            .clr_flow  (do_rd && hit_q && (sel == SEL_STS_WR)),
            .rptr      (rptr_all[gi]),
            .wptr      (wptr_all[gi]),
            .err_rd    (err_rd_all[gi]),
            .err_wr    (err_wr_all[gi]),
            .ovf       (ovf_all[gi]),
            .udf       (udf_all[gi])
        );
    end

    qpc_rdmux #(
        .NUM_Q (NUM_Q),
        .PTR_W (PTR_W)
    ) rdmux_i (
        .sel        (sel),
        .qidx       (qidx),
        .rptr_all   (rptr_all),
        .wptr_all   (wptr_all),
        .err_rd_all (err_rd_all),
        .err_wr_all (err_wr_all),
        .ovf_all    (ovf_all),
        .udf_all    (udf_all),
        .rdata      (mux_data)
    );

    always_comb begin
        bus_d.ready = do_wr || do_rd;
        bus_d.rdata = do_rd ? mux_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign bus_ready = bus_q.ready;
    assign bus_rdata = bus_q.rdata;

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> bus_ready);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> (!bus_ready && (bus_rdata == '0)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (sel == SEL_NONE)) |=> (bus_rdata == '0));

endmodule

// File: tb/qptr_ctrl_tb_top.sv
module qptr_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;
    localparam int LW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [19:0]       bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              bus_ready;
    logic [NQ*LW-1:0]  q_size_log2;

    // sizes: q0 16, q1 2^18, q2 4, q3 8
    assign q_size_log2 = {5'd3, 5'd2, 5'd18, 5'd4};

    always #(CLK_PERIOD/2) clk = ~clk;

    qptr_ctrl #(.NUM_Q(NQ)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready),
        .q_size_log2 (q_size_log2)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    int unsigned m_rp [NQ];
    int unsigned m_wp [NQ];
    int unsigned m_occ[NQ];
    bit m_ew[NQ], m_er[NQ], m_ov[NQ], m_ud[NQ];

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] qa(input int q, input int off);
        return 20'h80000 | 20'(q << 11) | 20'(off);
    endfunction

    function automatic int unsigned qsize(input int q);
        return 1 << q_size_log2[q*LW +: LW];
    endfunction

    // monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (rst_n && bus_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected ready", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [19:0] a, input logic [31:0] d, input string tag);
        int q;
        int off;
        q = int'(a[18:11]);
        off = int'(a[10:0]);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        exp_q.push_back(32'd0);
        tag_q.push_back({tag, " write completion"});
        if (a[19] && q < NQ && (off == 0 || off == 4)) begin
            if (d > 63) begin
                if (off == 4) m_ew[q] = 1; else m_er[q] = 1;
            end else if (off == 4) begin
                m_wp[q] = (m_wp[q] + d) % qsize(q);
                m_occ[q] = m_occ[q] + d;
                if (m_occ[q] > qsize(q)) begin
                    m_ov[q] = 1;
                    m_occ[q] = qsize(q);
                end
            end else begin
                if (d > m_occ[q]) m_ud[q] = 1;
                else begin
                    m_rp[q] = (m_rp[q] + d) % qsize(q);
                    m_occ[q] = m_occ[q] - d;
                end
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, input string tag);
        int q;
        int off;
        logic [31:0] e;
        q = int'(a[18:11]);
        off = int'(a[10:0]);
        e = 32'd0;
        if (a[19] && q < NQ && off == 8) begin
            e = {m_ew[q], m_er[q], 12'd0, 18'(m_rp[q])};
            m_ew[q] = 0; m_er[q] = 0;
        end else if (a[19] && q < NQ && off == 12) begin
            e = {m_ov[q], m_ud[q], 12'd0, 18'(m_wp[q])};
            m_ov[q] = 0; m_ud[q] = 0;
        end
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            m_rp[i] = 0; m_wp[i] = 0; m_occ[i] = 0;
            m_ew[i] = 0; m_er[i] = 0; m_ov[i] = 0; m_ud[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(bus_ready === 1'b0, "R11 ready low in reset", 32'(bus_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ready === 1'b0, "R11 ready low after reset", 32'(bus_ready), 32'd0);
        for (int q = 0; q < NQ; q++) begin
            rd(qa(q, 8), "R11 reset read-pointer status");
            rd(qa(q, 12), "R11 reset write-pointer status");
        end

        // basic adds on q0 (size 16)
        wr(qa(0, 4), 10, "R3");
        rd(qa(0, 12), "R3 write pointer after add 10");
        wr(qa(0, 0), 4, "R2");
        rd(qa(0, 8), "R2 read pointer after add 4");
        @(negedge clk);
        check(bus_ready === 1'b0, "R10 idle cycle ready low", 32'(bus_ready), 32'd0);

        // overflow with wrap on q0
        wr(qa(0, 4), 63, "R6");
        rd(qa(0, 12), "R6 overflow flag and wrapped pointer");
        rd(qa(0, 12), "R8 overflow flag cleared by read");

        // underflow on q0 (occupancy 16)
        wr(qa(0, 0), 20, "R7");
        rd(qa(0, 12), "R7 underflow flag");
        rd(qa(0, 8), "R7 read pointer unchanged");
        wr(qa(0, 0), 16, "R2 drain");
        rd(qa(0, 8), "R2 read pointer wraps after drain");

        // oversized adds on q1
        wr(qa(1, 4), 64, "R5");
        wr(qa(1, 0), 100, "R5");
        rd(qa(1, 12), "R5 write pointer unchanged");
        rd(qa(1, 8), "R5 both error flags");
        rd(qa(1, 8), "R8 error flags cleared by read");

        // small queue wrap on q2 (size 4)
        wr(qa(2, 4), 3, "R3");
        wr(qa(2, 0), 3, "R2");
        wr(qa(2, 4), 3, "R3");
        rd(qa(2, 12), "R3 write pointer wraps at size 4");
        rd(qa(2, 8), "R2 read pointer at 3");

        // isolation between queues
        wr(qa(3, 4), 5, "R1");
        rd(qa(3, 12), "R1 queue 3 window");
        rd(qa(2, 12), "R1 queue 2 untouched");
        wr(qa(2, 4), 40, "R6");
        wr(qa(3, 4), 40, "R6");
        rd(qa(2, 12), "R8 clear queue 2 flags");
        rd(qa(3, 12), "R8 queue 3 flag kept");

        // unmapped accesses
        wr(qa(0, 16), 5, "R9");
        wr(20'h00004, 5, "R9");
        wr(qa(4, 4), 5, "R9");
        wr(qa(0, 8), 5, "R9");
        wr(qa(0, 12), 5, "R9");
        rd(qa(0, 16), "R9 unmapped offset reads zero");
        rd(20'h0000C, "R9 below region reads zero");
        rd(qa(5, 12), "R9 queue beyond count reads zero");
        rd(qa(0, 12), "R9 queue 0 write pointer unchanged");
        rd(qa(0, 8), "R9 queue 0 read pointer unchanged");

        // write wins over simultaneous read
        bus_rd = 1'b1;
        wr(qa(3, 4), 1, "R10 write with read");
        bus_rd = 1'b0;
        rd(qa(3, 12), "R10 write applied, read dropped");

        // full 18-bit walk on q1
        for (int i = 0; i < 4161; i++) wr(qa(1, 4), 63, "R4");
        rd(qa(1, 12), "R4 write pointer all ones");
        wr(qa(1, 4), 2, "R6");
        rd(qa(1, 12), "R6 overflow at full-size wrap");
        wr(qa(1, 0), 63, "R2");
        rd(qa(1, 8), "R4 read pointer readback");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all accesses completed",
              32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule